// File: doc/BRIEF.md
# USB Host Interrupt Status Register

This block keeps the four sticky event flags that a USB host controller raises toward software: transfer completion, transaction error, root-port change and frame-list wrap. Event inputs arrive as pulses or levels from the rest of the controller: descriptor completion qualifiers, a short-packet pulse, the running frame index, the per-port change, resume and owner bits, and a strobe for the return from low power to the active state. The block turns them into set requests, and each flag then stays at 1 until software clears it by writing a one to its position.

A small register port gives access to two words. Address 0 holds the status flags and clears them on write-one. Address 1 holds a read/write enable mask. The single interrupt output is high whenever any flag is high while its enable bit is also high. Port edges and frame-index toggles are found by comparing each input with a registered copy from the previous cycle, so every event shows up in the flags one clock edge after it is presented.

Top module: `usb_irq_status`

## Requirements
- R1: After reset the status flags and the enable mask are all 0, both register addresses read 0, and irqOut is 0.
- R2: Reading address 0 (regAddr=0) returns the flags in bits [3:0], with bit 0 = transfer interrupt, bit 1 = error, bit 2 = port change and bit 3 = frame rollover. Reading address 1 returns the enable mask in the same bit positions. Bits [DATA_W-1:4] always read 0, whatever was written to them.
- R3: A write to address 0 clears every flag whose regWdata bit is 1 and leaves every flag whose bit is 0 unchanged. Without a set or a write, a flag holds its value.
- R4: Bit 0 sets on a cycle with tdDone=1 and tdIoc=1. tdDone on its own, with tdIoc=0 and shortPkt=0, does not set bit 0.
- R5: shortPkt=1 sets bit 0 whatever the values of tdDone and tdIoc.
- R6: tdDone=1 with tdError=1 sets bit 1. If tdIoc=1 in the same cycle, bits 1 and 0 are both set by that one event.
- R7: Each toggle of frameIdx bit ROLL_BIT, in either direction, sets bit 3. Changes on any other frameIdx bit set nothing.
- R8: A 0-to-1 transition of portConnChg, portEnChg or portOcChg on a port whose portOwner bit is 0 sets bit 2. Transitions on ports with portOwner=1, and 1-to-0 transitions, set nothing.
- R9: A 0-to-1 transition of portResume on a port whose portOwner bit is 0 sets bit 2.
- R10: On a cycle with pwrWake=1, bit 2 is loaded with the OR of all change and resume bits of all ports, regardless of owner. This load can clear bit 2, and it takes precedence over a write-one-to-clear of bit 2 in the same cycle.
- R11: When a set event and a write-one-to-clear hit the same flag in the same cycle, the flag ends at 1.
- R12: irqOut is 1 exactly when some flag and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tdDone | input | 1 | Pulse: a transfer descriptor has completed |
| tdIoc | input | 1 | Completing descriptor requested interrupt on completion |
| tdError | input | 1 | Completing transaction ended in an error |
| shortPkt | input | 1 | Pulse: short packet received |
| frameIdx | input | FRAME_IDX_W | Running frame index |
| portConnChg | input | NUM_PORTS | Per-port connect-status change bits |
| portEnChg | input | NUM_PORTS | Per-port enable/disable change bits |
| portOcChg | input | NUM_PORTS | Per-port over-current change bits |
| portResume | input | NUM_PORTS | Per-port resume bits forced by a J-K transition |
| portOwner | input | NUM_PORTS | Per-port owner; 0 means this controller owns the port |
| pwrWake | input | 1 | Strobe: low-power to active transition |
| regWe | input | 1 | Register write enable |
| regAddr | input | 1 | Register select: 0 status, 1 enable |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data (combinational on regAddr) |
| irqOut | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check write-one-to-clear, flag hold without a write, the short-packet and error-with-completion sets, the rule that a set beats a clear, and the consistency of irqOut with the flags and the mask. The ownership gating of port edges, the frame-bit selectivity, the wake-time load and its ability to clear a flag depend on multi-cycle input histories. Only the bench's scenarios show these, by sweeping every descriptor qualifier combination, every port with every change kind under both owners, every frame-index bit, and every enable mask against every clear mask.

// File: rtl/usb_irq_pkg.sv
`timescale 1ns/1ps
package usb_irq_pkg;

  localparam int FLAG_W   = 4;
  localparam int BIT_XFER = 0;
  localparam int BIT_ERR  = 1;
  localparam int BIT_PORT = 2;
  localparam int BIT_ROLL = 3;

  localparam int CHG_KINDS = 4;  // connect, enable, over-current, resume

  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_ENABLE = 1'b1;

  // Strobes from control to the flag datapath
  typedef struct packed {
    logic [FLAG_W-1:0] setMask;
    logic [FLAG_W-1:0] clrMask;
    logic              portLoad;
    logic              portLoadVal;
  } flagCmd_t;

endpackage

// File: rtl/usb_irq_port_edge.sv
`timescale 1ns/1ps
module usb_irq_port_edge
  import usb_irq_pkg::*;
#(
  parameter int KINDS = CHG_KINDS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [KINDS-1:0] chgBits,
  input  logic             owner,
  output logic             hit,
  output logic             level
);

  logic [KINDS-1:0] prevBits;
  logic [KINDS-1:0] riseBits;

  always_ff @(posedge clk) begin
    if (!rstN) prevBits <= '0;
    else       prevBits <= chgBits;
  end

  always_comb begin
    riseBits = chgBits & ~prevBits;
    hit      = (!owner) && (|riseBits);
    level    = |chgBits;
  end

endmodule

// File: rtl/usb_irq_ctrl.sv
`timescale 1ns/1ps
module usb_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int FRAME_IDX_W = 14,
  parameter int ROLL_BIT    = 13
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tdDone,
  input  logic                   tdIoc,
  input  logic                   tdError,
  input  logic                   shortPkt,
  input  logic [FRAME_IDX_W-1:0] frameIdx,
  input  logic [NUM_PORTS-1:0]   portConnChg,
  input  logic [NUM_PORTS-1:0]   portEnChg,
  input  logic [NUM_PORTS-1:0]   portOcChg,
  input  logic [NUM_PORTS-1:0]   portResume,
  input  logic [NUM_PORTS-1:0]   portOwner,
  input  logic                   pwrWake,
  input  logic                   regWe,
  input  logic                   regAddr,
  input  logic [FLAG_W-1:0]      regWlow,
  output flagCmd_t               cmd
);

  logic [NUM_PORTS-1:0] portHit;
  logic [NUM_PORTS-1:0] portLevel;
  logic                 rollPrev;
  logic                 unusedFrameBits;

  assign unusedFrameBits = ^{frameIdx[FRAME_IDX_W-1:0]};

  genvar g;
  generate
    for (g = 0; g < NUM_PORTS; g++) begin : gPort
      usb_irq_port_edge #(.KINDS(CHG_KINDS)) uEdge (
        .clk     (clk),
        .rstN    (rstN),
        .chgBits ({portResume[g], portOcChg[g], portEnChg[g], portConnChg[g]}),
        .owner   (portOwner[g]),
        .hit     (portHit[g]),
        .level   (portLevel[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) rollPrev <= 1'b0;
    else       rollPrev <= frameIdx[ROLL_BIT];
  end

  always_comb begin
    cmd                   = '0;
    cmd.setMask[BIT_XFER] = (tdDone && tdIoc) || shortPkt;
    cmd.setMask[BIT_ERR]  = tdDone && tdError;
    cmd.setMask[BIT_PORT] = |portHit;
    cmd.setMask[BIT_ROLL] = frameIdx[ROLL_BIT] ^ rollPrev;
    cmd.clrMask           = (regWe && (regAddr == ADDR_STATUS)) ? regWlow : '0;
    cmd.portLoad          = pwrWake;
    cmd.portLoadVal       = |portLevel;
  end

endmodule

// File: rtl/usb_irq_dp.sv
`timescale 1ns/1ps
module usb_irq_dp
  import usb_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagCmd_t          cmd,
  input  logic              regWe,
  input  logic              regAddr,
  input  logic [FLAG_W-1:0] regWlow,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut,
  output logic [FLAG_W-1:0] statusQ,
  output logic [FLAG_W-1:0] enableQ
);

  localparam int PAD_W = DATA_W - FLAG_W;

  logic [FLAG_W-1:0] statusD;
  logic [FLAG_W-1:0] readSel;

  always_comb begin
    statusD = (statusQ & ~cmd.clrMask) | cmd.setMask;
    if (cmd.portLoad) statusD[BIT_PORT] = cmd.portLoadVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
    end else begin
      statusQ <= statusD;
      if (regWe && (regAddr == ADDR_ENABLE)) enableQ <= regWlow;
    end
  end

  always_comb begin
    readSel  = (regAddr == ADDR_ENABLE) ? enableQ : statusQ;
    regRdata = {{PAD_W{1'b0}}, readSel};
    irqOut   = |(statusQ & enableQ);
  end

endmodule

// File: rtl/usb_irq_status.sv
`timescale 1ns/1ps
module usb_irq_status
  import usb_irq_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int FRAME_IDX_W = 14,
  parameter int ROLL_BIT    = 13,
  parameter int DATA_W      = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tdDone,
  input  logic                   tdIoc,
  input  logic                   tdError,
  input  logic                   shortPkt,
  input  logic [FRAME_IDX_W-1:0] frameIdx,
  input  logic [NUM_PORTS-1:0]   portConnChg,
  input  logic [NUM_PORTS-1:0]   portEnChg,
  input  logic [NUM_PORTS-1:0]   portOcChg,
  input  logic [NUM_PORTS-1:0]   portResume,
  input  logic [NUM_PORTS-1:0]   portOwner,
  input  logic                   pwrWake,
  input  logic                   regWe,
  input  logic                   regAddr,
  input  logic [DATA_W-1:0]      regWdata,
  output logic [DATA_W-1:0]      regRdata,
  output logic                   irqOut
);

  flagCmd_t          cmd;
  logic [FLAG_W-1:0] statusQ;
  logic [FLAG_W-1:0] enableQ;
  logic [FLAG_W-1:0] regWlow;
  logic              unusedWdataHigh;

  assign regWlow         = regWdata[FLAG_W-1:0];
  assign unusedWdataHigh = ^regWdata[DATA_W-1:FLAG_W];

  usb_irq_ctrl #(
    .NUM_PORTS   (NUM_PORTS),
    .FRAME_IDX_W (FRAME_IDX_W),
    .ROLL_BIT    (ROLL_BIT)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .tdDone      (tdDone),
    .tdIoc       (tdIoc),
    .tdError     (tdError),
    .shortPkt    (shortPkt),
    .frameIdx    (frameIdx),
    .portConnChg (portConnChg),
    .portEnChg   (portEnChg),
    .portOcChg   (portOcChg),
    .portResume  (portResume),
    .portOwner   (portOwner),
    .pwrWake     (pwrWake),
    .regWe       (regWe),
    .regAddr     (regAddr),
    .regWlow     (regWlow),
    .cmd         (cmd)
  );

  usb_irq_dp #(.DATA_W(DATA_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWlow  (regWlow),
    .regRdata (regRdata),
    .irqOut   (irqOut),
    .statusQ  (statusQ),
    .enableQ  (enableQ)
  );

endmodule

// File: rtl/usb_irq_chk.sv
`timescale 1ns/1ps
module usb_irq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tdDone,
  input logic       tdIoc,
  input logic       tdError,
  input logic       shortPkt,
  input logic       regWe,
  input logic       regAddr,
  input logic [3:0] regWlow,
  input logic [3:0] statusQ,
  input logic [3:0] enableQ,
  input logic       irqOut
);

  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 1'b0 && regWlow[1] && !(tdDone && tdError)) |=> !statusQ[1]);

  a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ[1] && !(regWe && regAddr == 1'b0 && regWlow[1])) |=> statusQ[1]);

  a_r5_short_sets: assert property (@(posedge clk) disable iff (!rstN)
    shortPkt |=> statusQ[0]);

  a_r6_err_ioc_both: assert property (@(posedge clk) disable iff (!rstN)
    (tdDone && tdError && tdIoc) |=> (statusQ[1:0] == 2'b11));

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (tdDone && tdIoc && regWe && regAddr == 1'b0 && regWlow[0]) |=> statusQ[0]);

  a_r12_irq_raised: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & enableQ) != 4'b0) |-> irqOut);

  a_r12_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ == 4'b0) |-> !irqOut);

endmodule

bind usb_irq_status usb_irq_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .tdDone   (tdDone),
  .tdIoc    (tdIoc),
  .tdError  (tdError),
  .shortPkt (shortPkt),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .regWlow  (regWlow),
  .statusQ  (statusQ),
  .enableQ  (enableQ),
  .irqOut   (irqOut)
);

// File: tb/sim_usb_irq_status.sv
`timescale 1ns/1ps
module sim_usb_irq_status;

  localparam int NP = 4;
  localparam int FW = 14;
  localparam int RB = 13;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tdDone = 0, tdIoc = 0, tdError = 0, shortPkt = 0;
  logic [FW-1:0] frameIdx = '0;
  logic [NP-1:0] portConnChg = '0, portEnChg = '0, portOcChg = '0, portResume = '0, portOwner = '0;
  logic          pwrWake = 0;
  logic          regWe = 0;
  logic          regAddr = 0;
  logic [DW-1:0] regWdata = '0;
  logic [DW-1:0] regRdata;
  logic          irqOut;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  usb_irq_status #(.NUM_PORTS(NP), .FRAME_IDX_W(FW), .ROLL_BIT(RB), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .tdDone(tdDone), .tdIoc(tdIoc), .tdError(tdError),
    .shortPkt(shortPkt), .frameIdx(frameIdx), .portConnChg(portConnChg),
    .portEnChg(portEnChg), .portOcChg(portOcChg), .portResume(portResume),
    .portOwner(portOwner), .pwrWake(pwrWake), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic readReg(input logic a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  task automatic writeReg(input logic a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    step();
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic setPortBit(input int p, input int k, input logic v);
    case (k)
      0: portConnChg[p] = v;
      1: portEnChg[p]   = v;
      2: portOcChg[p]   = v;
      default: portResume[p] = v;
    endcase
  endtask

  task automatic setAll();
    portOwner = '0;
    tdDone = 1; tdIoc = 1; tdError = 1;
    frameIdx[RB] = ~frameIdx[RB];
    portConnChg[0] = 1'b1;
    step();
    tdDone = 0; tdIoc = 0; tdError = 0;
    portConnChg[0] = 1'b0;
    step();
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [3:0]  exp4;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    readReg(0, v); check("R1 status", v, 0);
    readReg(1, v); check("R1 enable", v, 0);
    check("R1 irq", {31'b0, irqOut}, 0);

    // R2: upper bits read zero
    writeReg(1, 32'hFFFF_FFFF);
    readReg(1, v); check("R2 enable width", v, 32'hF);
    writeReg(1, 0);

    // R4/R5/R6: every descriptor qualifier combination
    for (int c = 0; c < 16; c++) begin
      logic d, i, e, s;
      string tag;
      writeReg(0, 32'hF);
      {d, i, e, s} = c[3:0];
      tdDone = d; tdIoc = i; tdError = e; shortPkt = s;
      step();
      tdDone = 0; tdIoc = 0; tdError = 0; shortPkt = 0;
      readReg(0, v);
      exp4 = {2'b00, d & e, (d & i) | s};
      tag = s ? "R5 short" : ((d & e) ? "R6 error" : "R4 xfer");
      check(tag, v, {28'b0, exp4});
    end

    // R3: hold without write, clear only written ones
    writeReg(0, 32'hF);
    tdDone = 1; tdIoc = 1; tdError = 1; step(); tdDone = 0; tdIoc = 0; tdError = 0;
    step(); step();
    readReg(0, v); check("R3 hold", v, 32'h3);
    writeReg(0, 32'h2);
    readReg(0, v); check("R3 partial clear", v, 32'h1);

    // R7: each frame bit
    for (int b = 0; b < FW; b++) begin
      writeReg(0, 32'hF);
      frameIdx[b] = ~frameIdx[b];
      step();
      readReg(0, v);
      check("R7 frame bit", v, (b == RB) ? 32'h8 : 32'h0);
    end
    writeReg(0, 32'hF);
    frameIdx[RB] = ~frameIdx[RB];
    step();
    readReg(0, v); check("R7 second toggle", v, 32'h8);

    // R8/R9: each port, each change kind, both owners
    for (int p = 0; p < NP; p++) begin
      for (int k = 0; k < 4; k++) begin
        for (int o = 0; o < 2; o++) begin
          string tag;
          tag = (k == 3) ? "R9 resume" : "R8 change";
          writeReg(0, 32'hF);
          portOwner[p] = o[0];
          setPortBit(p, k, 1'b1);
          step();
          readReg(0, v);
          check(tag, v, (o == 0) ? 32'h4 : 32'h0);
          writeReg(0, 32'hF);
          readReg(0, v);
          check("R8 level no reset", v, 0);
          setPortBit(p, k, 1'b0);
          step();
          readReg(0, v);
          check("R8 falling ignored", v, 0);
          portOwner[p] = 1'b0;
        end
      end
    end

    // R10: wake loads the OR of all change bits
    writeReg(0, 32'hF);
    portOwner = '1;
    portOcChg[2] = 1'b1;
    step();
    readReg(0, v); check("R8 foreign port", v, 0);
    pwrWake = 1; step(); pwrWake = 0;
    readReg(0, v); check("R10 wake load one", v, 32'h4);
    portOcChg[2] = 1'b0;
    step();
    pwrWake = 1; step(); pwrWake = 0;
    readReg(0, v); check("R10 wake load zero", v, 0);
    portResume[1] = 1'b1;
    step();
    pwrWake = 1;
    writeReg(0, 32'h4);
    pwrWake = 0;
    readReg(0, v); check("R10 wake beats clear", v, 32'h4);
    portResume[1] = 1'b0;
    portOwner = '0;
    step();
    writeReg(0, 32'hF);

    // R11: set beats clear
    tdDone = 1; tdIoc = 1;
    writeReg(0, 32'h1);
    tdDone = 0; tdIoc = 0;
    readReg(0, v); check("R11 xfer set wins", v, 32'h1);
    writeReg(0, 32'hF);
    frameIdx[RB] = ~frameIdx[RB];
    writeReg(0, 32'h8);
    readReg(0, v); check("R11 roll set wins", v, 32'h8);

    // R12/R2/R3: all enable masks against all clear masks
    for (int en = 0; en < 16; en++) begin
      writeReg(1, en);
      readReg(1, v); check("R2 enable readback", v, en);
      for (int m = 0; m < 16; m++) begin
        logic [3:0] left;
        setAll();
        writeReg(0, m);
        left = 4'hF & ~m[3:0];
        readReg(0, v); check("R3 clear mask", v, {28'b0, left});
        check("R12 irq", {31'b0, irqOut}, {31'b0, |(left & en[3:0])});
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule